// File: doc/BRIEF.md
# Processor Status Word with Register-Bank Window

This block holds the 8-bit status word of a small 8-bit controller core. When the adder/subtractor reports an operation, the block computes the carry, half-carry and overflow flags from the two operands and the operation kind, and stores them. The parity bit is never stored. It is formed every cycle from the live accumulator value.

Software can load the word as a whole byte or change one bit at a time. Three stored bits have no arithmetic meaning: a user flag and two bank-select bits.

The bank-select bits place a window of eight working registers in one of four 8-byte banks at the bottom of internal RAM. The block turns a 3-bit register index into the 5-bit RAM address that the index names in the current bank. The status word is laid out as follows:

| Bit | Meaning |
|-----|---------|
| 7 | carry/borrow |
| 6 | half-carry |
| 5 | user flag |
| 4 | bank high |
| 3 | bank low |
| 2 | overflow |
| 1 | reserved, reads 0 |
| 0 | parity |

Top module: `stat_word_unit`

## Requirements
- R1: A synchronous active-high reset clears stored bits 7..1 to 0. This selects bank 0, so register index i maps to address i.
- R2: The register address is {bank high, bank low, index}. Bank n places R0..R7 at addresses 8n..8n+7.
- R3: Bit 0 (`parity_o`) is 1 exactly when the accumulator input holds an odd number of ones. It follows the accumulator in the same cycle, and no byte or bit write can change it.
- R4: On an arithmetic operation, CY (bit 7) takes the carry out of bit 7 for additions, or the borrow for subtractions. The new value is visible one cycle after the operation strobe.
- R5: On an arithmetic operation, AC (bit 6) takes the carry out of bit 3 for additions, or the borrow into bit 4 for subtractions.
- R6: On an arithmetic operation, OV (bit 2) is set exactly when the signed result leaves the range -128..127. This is the case for positive+positive=negative, negative+negative=positive, positive-negative=negative and negative-positive=positive.
- R7: A byte write loads bits 7..2 from the write data. Bit 1 always reads 0.
- R8: A bit write stores the given value into the bit numbered by the 3-bit select when the select is 2..7. Selects 0 and 1 leave the word unchanged.
- R9: When requests coincide, a byte write beats a bit write, and a bit write beats an arithmetic update. An arithmetic update never touches bits 5, 4 and 3.
- R10: Operation kind encoding is 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow. Kinds 01 and 11 use the stored CY as carry/borrow in; kinds 00 and 10 use 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Live accumulator value for parity |
| op_valid_i | input | 1 | Arithmetic operation strobe |
| op_kind_i | input | 2 | Operation kind (R10 encoding) |
| op_a_i | input | 8 | First operand |
| op_b_i | input | 8 | Second operand (subtrahend for subtractions) |
| wr_byte_en_i | input | 1 | Whole-word write enable |
| wr_byte_i | input | 8 | Whole-word write data |
| wr_bit_en_i | input | 1 | Single-bit write enable |
| wr_bit_sel_i | input | 3 | Bit number for single-bit write |
| wr_bit_val_i | input | 1 | Value for single-bit write |
| reg_idx_i | input | 3 | Working register index |
| status_o | output | 8 | Status word |
| cy_o | output | 1 | Carry/borrow flag |
| ac_o | output | 1 | Half-carry flag |
| ov_o | output | 1 | Overflow flag |
| f0_o | output | 1 | User flag |
| parity_o | output | 1 | Accumulator parity |
| bank_o | output | 2 | Selected bank |
| reg_addr_o | output | 5 | RAM address of the indexed register |

## Verification
Plain addition is swept over every pair of operands. This separates carry from half-carry and from signed overflow at every boundary: 0x0F+0x01, 0x7F+0x01, 0x80+0x80 and 0xFF+0x01.

Subtraction is swept over all minuends against a strided set of subtrahends. The two carry-in kinds are run back to back, so the stored carry chains from one operation to the next. This shows whether the carry-in is taken from the register or forced to zero.

The accumulator is swept over all 256 values while software keeps trying to set bit 0, which tells live parity apart from a stored bit. Every bank is walked with every index, single bits are written at every select, and coinciding requests expose the priority order.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        K_ADD  = 2'b00,
        K_ADDC = 2'b01,
        K_SUB  = 2'b10,
        K_SUBB = 2'b11
    } alu_kind_e;

    // bit 7 first
    typedef struct packed {
        logic cy;
        logic ac;
        logic f0;
        logic rs1;
        logic rs0;
        logic ov;
        logic rsv;
        logic p;
    } status_t;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;

    localparam int POS_RSV = 1;
    localparam int POS_P   = 0;

    // true when a bit number refers to a software-writable bit
    function automatic logic bit_writable(input logic [2:0] sel);
        return (sel != 3'(POS_P)) && (sel != 3'(POS_RSV));
    endfunction

endpackage

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
    import psw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LOW_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_kind_e         kind_i,
    input  logic              cy_i,
    output arith_flags_t      flags_o
);
    logic              use_cin;
    logic              is_sub;
    logic              ci;
    logic [DATA_W-1:0] bx;
    logic [DATA_W:0]   full_sum;
    logic [LOW_W:0]    low_sum;
    logic [DATA_W-1:0] top_in_sum;

    always_comb begin
        use_cin = kind_i[0] & cy_i;
        is_sub  = kind_i[1];
        // subtraction as a + ~b + ~borrow_in
        bx      = is_sub ? ~b_i : b_i;
        ci      = is_sub ? ~use_cin : use_cin;
        full_sum   = {1'b0, a_i} + {1'b0, bx} + {{DATA_W{1'b0}}, ci};
        low_sum    = {1'b0, a_i[LOW_W-1:0]} + {1'b0, bx[LOW_W-1:0]}
                   + {{LOW_W{1'b0}}, ci};
        top_in_sum = {1'b0, a_i[DATA_W-2:0]} + {1'b0, bx[DATA_W-2:0]}
                   + {{(DATA_W-1){1'b0}}, ci};
        flags_o.cy = full_sum[DATA_W] ^ is_sub;
        flags_o.ac = low_sum[LOW_W] ^ is_sub;
        flags_o.ov = top_in_sum[DATA_W-1] ^ full_sum[DATA_W];
    end

endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] v_i,
    output logic         odd_o
);
    logic [W-1:0] chain;

    assign chain[0] = v_i[0];
    generate
        for (genvar i = 1; i < W; i++) begin : g_chain
            assign chain[i] = chain[i-1] ^ v_i[i];
        end
    endgenerate
    assign odd_o = chain[W-1];

endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
    parameter int IDX_W  = 3,
    parameter int BANK_W = 2,
    localparam int ADDR_W = IDX_W + BANK_W
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    assign addr_o = {bank_i, idx_i};
endmodule

// File: rtl/stat_word_unit.sv
module stat_word_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    localparam int BANK_W = 2,
    localparam int ADDR_W = IDX_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              op_valid_i,
    input  logic [1:0]        op_kind_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              wr_byte_en_i,
    input  logic [7:0]        wr_byte_i,
    input  logic              wr_bit_en_i,
    input  logic [2:0]        wr_bit_sel_i,
    input  logic              wr_bit_val_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    output logic [7:0]        status_o,
    output logic              cy_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              f0_o,
    output logic              parity_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] reg_addr_o
);
    status_t      st_q, st_d;
    arith_flags_t gen_flags;
    logic         par;
    logic [7:0]   bit_img;

    psw_flag_gen #(.DATA_W(DATA_W), .LOW_W(4)) flag_gen_i (
        .a_i     (op_a_i),
        .b_i     (op_b_i),
        .kind_i  (alu_kind_e'(op_kind_i)),
        .cy_i    (st_q.cy),
        .flags_o (gen_flags)
    );

    psw_parity #(.W(DATA_W)) parity_i (
        .v_i   (acc_i),
        .odd_o (par)
    );

    psw_bank_map #(.IDX_W(IDX_W), .BANK_W(BANK_W)) bank_map_i (
        .bank_i (bank_o),
        .idx_i  (reg_idx_i),
        .addr_o (reg_addr_o)
    );

    always_comb begin
        st_d    = st_q;
        bit_img = st_q;
        if (wr_byte_en_i) begin
            st_d     = status_t'(wr_byte_i);
            st_d.rsv = 1'b0;
            st_d.p   = 1'b0;
        end else if (wr_bit_en_i) begin
            if (bit_writable(wr_bit_sel_i)) begin
                bit_img[wr_bit_sel_i] = wr_bit_val_i;
            end
            st_d = status_t'(bit_img);
        end else if (op_valid_i) begin
            st_d.cy = gen_flags.cy;
            st_d.ac = gen_flags.ac;
            st_d.ov = gen_flags.ov;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign status_o = {st_q.cy, st_q.ac, st_q.f0, st_q.rs1, st_q.rs0,
                       st_q.ov, 1'b0, par};
    assign cy_o     = st_q.cy;
    assign ac_o     = st_q.ac;
    assign ov_o     = st_q.ov;
    assign f0_o     = st_q.f0;
    assign parity_o = par;
    assign bank_o   = {st_q.rs1, st_q.rs0};

    // R1: reset clears the stored bits
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> status_o[7:1] == 7'd0);

    // R7: byte write lands in bits 7..2
    assert_byte_load_R7: assert property (@(posedge clk) disable iff (rst)
        wr_byte_en_i |=> status_o[7:2] == $past(wr_byte_i[7:2]));

    // R7: reserved bit reads zero
    assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (rst)
        status_o[1] == 1'b0);

    // R8: bit write of a writable position stores the value
    assert_bit_store_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_bit_en_i && !wr_byte_en_i && wr_bit_sel_i >= 3'd2)
        |=> status_o[$past(wr_bit_sel_i)] == $past(wr_bit_val_i));

    // R9: arithmetic update leaves user flag and bank alone
    assert_arith_keeps_bank_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !wr_byte_en_i && !wr_bit_en_i)
        |=> $stable(bank_o) && $stable(f0_o));

    // R6: overflow on plain add only when operand signs agree
    assert_add_ov_sign_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !wr_byte_en_i && !wr_bit_en_i && op_kind_i == 2'b00)
        |=> (!ov_o || ($past(op_a_i[DATA_W-1]) == $past(op_b_i[DATA_W-1]))));

endmodule

// File: tb/stat_word_unit_tb.sv
module stat_word_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0;
    logic       op_valid_i = 1'b0;
    logic [1:0] op_kind_i = '0;
    logic [7:0] op_a_i = '0, op_b_i = '0;
    logic       wr_byte_en_i = 1'b0;
    logic [7:0] wr_byte_i = '0;
    logic       wr_bit_en_i = 1'b0;
    logic [2:0] wr_bit_sel_i = '0;
    logic       wr_bit_val_i = 1'b0;
    logic [2:0] reg_idx_i = '0;
    logic [7:0] status_o;
    logic       cy_o, ac_o, ov_o, f0_o, parity_o;
    logic [1:0] bank_o;
    logic [4:0] reg_addr_o;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] m = '0;

    always #2.5 clk = ~clk;

    stat_word_unit dut_i (
        .clk(clk), .rst(rst), .acc_i(acc_i), .op_valid_i(op_valid_i),
        .op_kind_i(op_kind_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
        .wr_byte_en_i(wr_byte_en_i), .wr_byte_i(wr_byte_i),
        .wr_bit_en_i(wr_bit_en_i), .wr_bit_sel_i(wr_bit_sel_i),
        .wr_bit_val_i(wr_bit_val_i), .reg_idx_i(reg_idx_i),
        .status_o(status_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
        .f0_o(f0_o), .parity_o(parity_o), .bank_o(bank_o),
        .reg_addr_o(reg_addr_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        op_valid_i = 0; wr_byte_en_i = 0; wr_bit_en_i = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic byte_wr(input logic [7:0] d);
        wr_byte_en_i = 1; wr_byte_i = d;
        step();
        m = {d[7:2], 2'b00};
    endtask

    function automatic logic [7:0] expect_word(input logic [7:0] acc);
        return {m[7:1], ^acc};
    endfunction

    // reference arithmetic on integers
    task automatic do_op(input logic [1:0] kind, input int a, input int b);
        int cin, r, lo, sa, sb, sr;
        logic ecy, eac, eov;
        cin = kind[0] ? int'(m[7]) : 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (kind[1]) begin
            r = a - b - cin; lo = (a % 16) - (b % 16) - cin; sr = sa - sb - cin;
            ecy = (r < 0); eac = (lo < 0);
        end else begin
            r = a + b + cin; lo = (a % 16) + (b % 16) + cin; sr = sa + sb + cin;
            ecy = (r > 255); eac = (lo > 15);
        end
        eov = (sr > 127) || (sr < -128);
        op_valid_i = 1; op_kind_i = kind; op_a_i = 8'(a); op_b_i = 8'(b);
        acc_i = 8'(a);
        step();
        m[7] = ecy; m[6] = eac; m[2] = eov;
        check("R4 R10 carry", {7'd0, cy_o}, {7'd0, ecy});
        check("R5 R10 half-carry", {7'd0, ac_o}, {7'd0, eac});
        check("R6 R10 overflow", {7'd0, ov_o}, {7'd0, eov});
        check("R9 bank/user kept", status_o & 8'h38, m & 8'h38);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        reg_idx_i = 3'd5; #1;
        check("R1 reset word", status_o, 8'h00);
        check("R1 reset address", {3'd0, reg_addr_o}, 8'h05);

        // R2: every bank and index
        for (int bk = 0; bk < 4; bk++) begin
            byte_wr(8'(bk << 3));
            check("R2 bank out", {6'd0, bank_o}, 8'(bk));
            for (int ix = 0; ix < 8; ix++) begin
                reg_idx_i = 3'(ix); #1;
                check("R2 address", {3'd0, reg_addr_o}, 8'(bk * 8 + ix));
            end
        end

        // R7: byte writes
        acc_i = 8'h00;
        byte_wr(8'hFF);
        check("R7 write FF", status_o, 8'hFC);
        byte_wr(8'hA5);
        check("R7 write A5", status_o, 8'hA4);

        // R3: parity sweep while trying to set bit 0
        for (int v = 0; v < 256; v++) begin
            acc_i = 8'(v);
            byte_wr(8'h01);
            check("R3 parity word", status_o, {7'd0, ^8'(v)});
            check("R3 parity pin", {7'd0, parity_o}, {7'd0, ^8'(v)});
        end

        // R8: single-bit writes
        acc_i = 8'h00;
        byte_wr(8'h00);
        for (int s = 7; s >= 0; s--) begin
            wr_bit_en_i = 1; wr_bit_sel_i = 3'(s); wr_bit_val_i = 1;
            step();
            if (s >= 2) m[s] = 1'b1;
            check("R8 bit set", status_o, expect_word(acc_i));
        end
        for (int s = 2; s < 8; s++) begin
            wr_bit_en_i = 1; wr_bit_sel_i = 3'(s); wr_bit_val_i = 0;
            step();
            m[s] = 1'b0;
            check("R8 bit clear", status_o, expect_word(acc_i));
        end

        // R9: priority
        wr_byte_en_i = 1; wr_byte_i = 8'h00;
        wr_bit_en_i = 1; wr_bit_sel_i = 3'd7; wr_bit_val_i = 1;
        step();
        check("R9 byte beats bit", status_o, 8'h00);
        wr_bit_en_i = 1; wr_bit_sel_i = 3'd5; wr_bit_val_i = 1;
        op_valid_i = 1; op_kind_i = 2'b00; op_a_i = 8'hFF; op_b_i = 8'h01;
        step();
        check("R9 bit beats arith", status_o, 8'h20);
        wr_byte_en_i = 1; wr_byte_i = 8'h00;
        op_valid_i = 1; op_kind_i = 2'b00; op_a_i = 8'hFF; op_b_i = 8'h01;
        step();
        check("R9 byte beats arith", status_o, 8'h00);

        // arithmetic sweeps with user flag and bank 2 set
        byte_wr(8'h30);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                do_op(2'b00, a, b);
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 3)
                do_op(2'b10, a, b);
        for (int a = 0; a < 256; a += 3)
            for (int b = 0; b < 256; b += 5) begin
                do_op(2'b01, a, b);
                do_op(2'b11, b, a);
            end
        check("R9 bank after sweep", {6'd0, bank_o}, 8'd2);

        // R1: reset after activity
        byte_wr(8'hFF);
        rst = 1; step(); rst = 0;
        acc_i = 8'h00; #1;
        check("R1 reset again", status_o, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule